// File: doc/BRIEF.md
# Programmable Sum-of-Products Logic Block

This block is the combinational core of one logic block in a programmable logic fabric. A set of input signals from the routing fabric is expanded into true and complemented literals. Each output cell owns a small group of dedicated product terms, and their OR forms a fast sum for that cell. A shared pool of product terms sits beside these groups. A fully programmable OR plane can add any pool term to any output, and one pool term can serve several outputs at once. This lets logic that outputs share be built only once.

A separate set of control terms produces signals that a neighbouring macrocell stage uses for clocks, presets, resets and output enables. Each control term can be set on its own to be either a product (AND) or a sum (OR) of the literals it selects. All configuration arrives as static input vectors whose widths come from the parameters. With the defaults there are 36 inputs, 16 outputs, 5 dedicated terms per output, 32 pool terms and 6 control terms. A test instance can be much smaller.

Top module: `plb_logic_block`

## Requirements
- R1: A product-term mask has 2*N_IN bits. Bit i connects the true form of input i, and bit N_IN+i connects its complement. The term is the AND of the literals it connects.
- R2: A product term with no connected literal evaluates to 0 for every input value.
- R3: Output o is the OR of its N_DED dedicated terms. Dedicated term t of output o uses mask bits starting at ((o*N_DED)+t)*2*N_IN.
- R4: Pool term p, whose mask starts at p*2*N_IN, adds to output o only when route bit o*N_POOL+p is set. A pool term that is not routed to an output has no effect on that output.
- R5: A single pool term that is routed to several outputs drives all of them at once.
- R6: All N_DED dedicated terms and all N_POOL pool terms can contribute to one output at the same time.
- R7: When bit c of ctl_is_sum is 0, control term c (mask starting at c*2*N_IN) is the AND of its selected literals. With no literal selected it is 0.
- R8: When bit c of ctl_is_sum is 1, control term c is the OR of its selected literals. With no literal selected it is 0.
- R9: A product term that connects both the true and the complement literal of the same input is 0 for every input value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| in_sig | input | N_IN | Input signals from the routing fabric |
| ded_mask | input | N_OUT*N_DED*2*N_IN | Literal masks of the dedicated product terms |
| pool_mask | input | N_POOL*2*N_IN | Literal masks of the shared pool terms |
| pool_route | input | N_OUT*N_POOL | OR-plane connections, bit o*N_POOL+p |
| ctl_mask | input | N_CTL*2*N_IN | Literal masks of the control terms |
| ctl_is_sum | input | N_CTL | Per control term: 1 selects sum form, 0 selects product form |
| mc_sum | output | N_OUT | Sum-of-products result for each output cell |
| ctl_out | output | N_CTL | Control-term results |

## Verification
The assertions recheck the logic on every evaluation. A product term or product-form control term that is high must have every selected literal high. An output may be high only when one of its dedicated terms or routed pool terms is high, and it must be high when a routed pool term is. A sum-form control term that is low must have every selected literal low. The bench scenarios cover the parts that a single-evaluation implication cannot express. These are the exact literal encoding, the effect of masks that are empty or contradictory, a pool term that is not routed having no effect, sharing of one term across outputs, and all terms feeding a single output across every input pattern.

// File: rtl/plb_pkg.sv
package plb_pkg;

   // Control-term form select, one bit per control term
   typedef enum logic {
      CTL_FORM_AND = 1'b0,
      CTL_FORM_OR  = 1'b1
   } ctl_form_e;

   // Literal width for a given input count: true plus complement
   function automatic int lit_width(input int n_in);
      return 2 * n_in;
   endfunction

endpackage

// File: rtl/plb_prod_term.sv
module plb_prod_term #(
   parameter int N_LIT = 72
) (
   input  logic [N_LIT-1:0] lits,
   input  logic [N_LIT-1:0] mask,
   output logic             term
);
   generate
      if (N_LIT < 2 || (N_LIT % 2) != 0) begin : g_bad_width
         $error("plb_prod_term: N_LIT must be even and at least 2");
      end
   endgenerate

   logic any_sel;
   logic all_hit;

   assign any_sel = |mask;
   assign all_hit = &(~mask | lits);
   assign term    = any_sel & all_hit;

   // R1: a high term implies every connected literal is high
   always_comb begin
      logic bad;
      bad = 1'b0;
      for (int i = 0; i < N_LIT; i++) begin
         if (term && mask[i] && !lits[i]) bad = 1'b1;
      end
      if (!$isunknown({term, mask, lits})) begin
         a_term_literals_r1: assert (!bad);
      end
   end
endmodule

// File: rtl/plb_ctl_term.sv
module plb_ctl_term
   import plb_pkg::*;
#(
   parameter int N_LIT = 72
) (
   input  logic [N_LIT-1:0] lits,
   input  logic [N_LIT-1:0] mask,
   input  logic             is_sum,
   output logic             term
);
   generate
      if (N_LIT < 2 || (N_LIT % 2) != 0) begin : g_bad_width
         $error("plb_ctl_term: N_LIT must be even and at least 2");
      end
   endgenerate

   logic and_form;
   logic or_form;
   ctl_form_e form;

   plb_prod_term #(.N_LIT(N_LIT)) u_and (
      .lits (lits),
      .mask (mask),
      .term (and_form)
   );

   assign or_form = |(mask & lits);
   assign form    = ctl_form_e'(is_sum);

   always_comb begin
      unique case (form)
         CTL_FORM_OR:  term = or_form;
         default:      term = and_form;
      endcase
   end

   // R7 / R8: form-specific consistency with the selected literals
   always_comb begin
      logic bad_and;
      logic bad_or;
      bad_and = 1'b0;
      bad_or  = 1'b0;
      for (int i = 0; i < N_LIT; i++) begin
         if (!is_sum && term && mask[i] && !lits[i]) bad_and = 1'b1;
         if (is_sum && !term && mask[i] && lits[i])  bad_or  = 1'b1;
      end
      if (!$isunknown({term, is_sum, mask, lits})) begin
         a_ctl_and_form_r7: assert (!bad_and);
         a_ctl_or_form_r8:  assert (!bad_or);
      end
   end
endmodule

// File: rtl/plb_or_plane.sv
module plb_or_plane #(
   parameter int N_OUT  = 16,
   parameter int N_DED  = 5,
   parameter int N_POOL = 32
) (
   input  logic [N_OUT*N_DED-1:0]  ded_terms,
   input  logic [N_POOL-1:0]       pool_terms,
   input  logic [N_OUT*N_POOL-1:0] route,
   output logic [N_OUT-1:0]        sums
);
   generate
      if (N_OUT < 1 || N_DED < 1 || N_POOL < 1) begin : g_bad_size
         $error("plb_or_plane: all sizes must be at least 1");
      end
   endgenerate

   for (genvar o = 0; o < N_OUT; o++) begin : g_out
      logic ded_any;
      logic pool_any;
      assign ded_any  = |ded_terms[o*N_DED +: N_DED];
      assign pool_any = |(pool_terms & route[o*N_POOL +: N_POOL]);
      assign sums[o]  = ded_any | pool_any;
   end

   // R3 / R4: output high exactly when a dedicated or routed pool term is high
   always_comb begin
      logic bad_src;
      logic bad_miss;
      bad_src  = 1'b0;
      bad_miss = 1'b0;
      for (int o = 0; o < N_OUT; o++) begin
         logic src;
         src = 1'b0;
         for (int t = 0; t < N_DED; t++)  if (ded_terms[o*N_DED+t]) src = 1'b1;
         for (int p = 0; p < N_POOL; p++) begin
            if (pool_terms[p] && route[o*N_POOL+p]) begin
               src = 1'b1;
               if (!sums[o]) bad_miss = 1'b1;
            end
         end
         if (sums[o] && !src) bad_src = 1'b1;
      end
      if (!$isunknown({sums, ded_terms, pool_terms, route})) begin
         a_sum_has_source_r3: assert (!bad_src);
         a_routed_pool_seen_r4: assert (!bad_miss);
      end
   end
endmodule

// File: rtl/plb_logic_block.sv
module plb_logic_block
   import plb_pkg::*;
#(
   parameter int N_IN   = 36,
   parameter int N_OUT  = 16,
   parameter int N_DED  = 5,
   parameter int N_POOL = 32,
   parameter int N_CTL  = 6
) (
   input  logic [N_IN-1:0]                  in_sig,
   input  logic [N_OUT*N_DED*2*N_IN-1:0]    ded_mask,
   input  logic [N_POOL*2*N_IN-1:0]         pool_mask,
   input  logic [N_OUT*N_POOL-1:0]          pool_route,
   input  logic [N_CTL*2*N_IN-1:0]          ctl_mask,
   input  logic [N_CTL-1:0]                 ctl_is_sum,
   output logic [N_OUT-1:0]                 mc_sum,
   output logic [N_CTL-1:0]                 ctl_out
);
   localparam int N_LIT  = lit_width(N_IN);
   localparam int N_DTRM = N_OUT * N_DED;

   generate
      if (N_IN < 1 || N_OUT < 1 || N_DED < 1 || N_POOL < 1 || N_CTL < 1) begin : g_bad_size
         $error("plb_logic_block: every size parameter must be at least 1");
      end
   endgenerate

   // Literal vector: true forms low, complements high
   logic [N_LIT-1:0]  lits;
   logic [N_DTRM-1:0] ded_terms;
   logic [N_POOL-1:0] pool_terms;

   assign lits = {~in_sig, in_sig};

   for (genvar d = 0; d < N_DTRM; d++) begin : g_ded
      plb_prod_term #(.N_LIT(N_LIT)) u_term (
         .lits (lits),
         .mask (ded_mask[d*N_LIT +: N_LIT]),
         .term (ded_terms[d])
      );
   end

   for (genvar p = 0; p < N_POOL; p++) begin : g_pool
      plb_prod_term #(.N_LIT(N_LIT)) u_term (
         .lits (lits),
         .mask (pool_mask[p*N_LIT +: N_LIT]),
         .term (pool_terms[p])
      );
   end

   plb_or_plane #(
      .N_OUT  (N_OUT),
      .N_DED  (N_DED),
      .N_POOL (N_POOL)
   ) u_or_plane (
      .ded_terms  (ded_terms),
      .pool_terms (pool_terms),
      .route      (pool_route),
      .sums       (mc_sum)
   );

   for (genvar c = 0; c < N_CTL; c++) begin : g_ctl
      plb_ctl_term #(.N_LIT(N_LIT)) u_ctl (
         .lits   (lits),
         .mask   (ctl_mask[c*N_LIT +: N_LIT]),
         .is_sum (ctl_is_sum[c]),
         .term   (ctl_out[c])
      );
   end
endmodule

// File: tb/plb_logic_block_bench.sv
module plb_logic_block_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NI = 4;
   localparam int NO = 3;
   localparam int ND = 2;
   localparam int NP = 3;
   localparam int NC = 2;
   localparam int L  = 2 * NI;

   logic clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic [NI-1:0]        in_sig;
   logic [NO*ND*L-1:0]   ded_mask;
   logic [NP*L-1:0]      pool_mask;
   logic [NO*NP-1:0]     pool_route;
   logic [NC*L-1:0]      ctl_mask;
   logic [NC-1:0]        ctl_is_sum;
   logic [NO-1:0]        mc_sum;
   logic [NC-1:0]        ctl_out;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   plb_logic_block #(
      .N_IN(NI), .N_OUT(NO), .N_DED(ND), .N_POOL(NP), .N_CTL(NC)
   ) u_plb_logic_block (
      .in_sig     (in_sig),
      .ded_mask   (ded_mask),
      .pool_mask  (pool_mask),
      .pool_route (pool_route),
      .ctl_mask   (ctl_mask),
      .ctl_is_sum (ctl_is_sum),
      .mc_sum     (mc_sum),
      .ctl_out    (ctl_out)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%b expected=%b", req, act, exp);
      end
   endtask

   task automatic clear_cfg();
      ded_mask = '0; pool_mask = '0; pool_route = '0;
      ctl_mask = '0; ctl_is_sum = '0;
   endtask

   // lit: i = true form of input i, NI+i = complement
   task automatic ded_lit(input int o, input int t, input int lit);
      ded_mask[(o*ND+t)*L + lit] = 1'b1;
   endtask
   task automatic pool_lit(input int p, input int lit);
      pool_mask[p*L + lit] = 1'b1;
   endtask
   task automatic ctl_lit(input int c, input int lit);
      ctl_mask[c*L + lit] = 1'b1;
   endtask

   task automatic apply(input logic [NI-1:0] v);
      in_sig = v;
      #(CLK_PERIOD/2);
   endtask

   task automatic t_reset_state();
      clear_cfg();
      for (int v = 0; v < 16; v++) begin
         apply(v[NI-1:0]);
         check("R2 empty terms", 8'(mc_sum), 8'd0);
         check("R7 empty product ctl", 8'(ctl_out), 8'd0);
      end
   endtask

   task automatic t_literals();
      clear_cfg();
      ded_lit(0, 0, 0); ded_lit(0, 0, NI+1);     // in0 & ~in1
      apply(4'b0001); check("R1 true/comp hit", 8'(mc_sum), 8'b001);
      apply(4'b0011); check("R1 comp literal low", 8'(mc_sum), 8'b000);
      apply(4'b0000); check("R1 true literal low", 8'(mc_sum), 8'b000);
   endtask

   task automatic t_dedicated_or();
      clear_cfg();
      ded_lit(1, 0, 2);        // in2
      ded_lit(1, 1, NI+3);     // ~in3
      apply(4'b0000); check("R3 second term", 8'(mc_sum), 8'b010);
      apply(4'b1000); check("R3 none", 8'(mc_sum), 8'b000);
      apply(4'b1100); check("R3 first term", 8'(mc_sum), 8'b010);
   endtask

   task automatic t_pool_share();
      clear_cfg();
      pool_lit(1, 1); pool_lit(1, 2);            // in1 & in2
      pool_route[0*NP+1] = 1'b1;
      pool_route[2*NP+1] = 1'b1;
      pool_lit(0, 0);                            // in0, routed nowhere
      apply(4'b0110); check("R5 shared pool", 8'(mc_sum), 8'b101);
      apply(4'b0010); check("R5 shared pool off", 8'(mc_sum), 8'b000);
      apply(4'b0001); check("R4 unrouted ignored", 8'(mc_sum), 8'b000);
      pool_route[1*NP+0] = 1'b1;
      apply(4'b0001); check("R4 routed adds", 8'(mc_sum), 8'b010);
   endtask

   task automatic t_contradiction();
      clear_cfg();
      ded_lit(2, 0, 0); ded_lit(2, 0, NI+0);
      for (int v = 0; v < 16; v++) begin
         apply(v[NI-1:0]);
         check("R9 x and not x", 8'(mc_sum), 8'd0);
      end
   endtask

   task automatic t_all_terms();
      clear_cfg();
      ded_lit(0, 0, 0); ded_lit(0, 1, 1);
      pool_lit(0, 2); pool_lit(1, 3);
      for (int i = 0; i < NI; i++) pool_lit(2, NI+i);
      for (int p = 0; p < NP; p++) pool_route[0*NP+p] = 1'b1;
      for (int v = 0; v < 16; v++) begin
         apply(v[NI-1:0]);
         check("R6 all terms cover", 8'(mc_sum), 8'b001);
      end
      pool_route[0*NP+2] = 1'b0;
      apply(4'b0000); check("R6 last pool removed", 8'(mc_sum), 8'b000);
   endtask

   task automatic t_ctl_forms();
      clear_cfg();
      ctl_lit(0, 0); ctl_lit(0, 3);              // product in0 & in3
      ctl_is_sum[1] = 1'b1;
      ctl_lit(1, 1); ctl_lit(1, NI+2);           // sum in1 | ~in2
      apply(4'b1001); check("R7 product high", 8'(ctl_out[0]), 8'd1);
      apply(4'b1000); check("R7 product low", 8'(ctl_out[0]), 8'd0);
      apply(4'b0100); check("R8 sum low", 8'(ctl_out[1]), 8'd0);
      apply(4'b0000); check("R8 sum comp", 8'(ctl_out[1]), 8'd1);
      apply(4'b0110); check("R8 sum true", 8'(ctl_out[1]), 8'd1);
      ctl_mask = '0;
      ctl_is_sum = 2'b11;
      apply(4'b1111); check("R8 empty sum", 8'(ctl_out), 8'd0);
   endtask

   initial begin
      clear_cfg();
      in_sig = '0;
      #(CLK_PERIOD/2);
      t_reset_state();
      t_literals();
      t_dedicated_or();
      t_pool_share();
      t_contradiction();
      t_all_terms();
      t_ctl_forms();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule